// File: doc/BRIEF.md
# Multi-Mode Nine-Bit Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port with three framing modes. One mode moves 8-bit characters. Two modes move 9-bit characters, where software supplies the ninth transmit bit and reads back the ninth received bit. Software loads bytes, sets the control and clock options, and collects received characters through a small register file. Each access is a single-cycle write strobe, and reads come from a combinational read port.

The bit clock is built from a 16x oversampling tick. The tick comes from one of three sources. The first is a fixed division of the system clock. The second is a 16-bit reloading divisor generator. The third is an external timer-overflow pulse, which can be halved. The receiver finds a start bit on a falling edge, checks it at mid-bit, and takes every bit by majority vote of three mid-bit samples. A stop bit that reads as 0 is reported as a framing error. A remap option shows that error in the top bit of the control register.

Register map (addresses on `wr_addr`/`rd_addr`): 0 control, 1 data (a write sends, a read returns the last received byte), 2 status, 3 divisor low byte, 4 divisor high byte, 5 clock options.

Top module: `uart9_core`

## Requirements
- R1: Control bits 7:6 select the mode: 01 is the 8-bit variable-rate mode, 10 the 9-bit fixed-rate mode, 11 the 9-bit variable-rate mode. In 01 a write to the data register sends 10 bits on `txd`: a 0 start bit, the byte LSB first, then a 1 stop bit. `txd` idles at 1.
- R2: In modes 10 and 11 a data write sends 11 bits: start 0, the byte LSB first, the value of control bit 3, then stop 1.
- R3: In mode 01 a received byte is read from the data register and the received stop bit appears in control bit 2.
- R4: In modes 10 and 11 the received ninth bit appears in control bit 2.
- R5: In mode 10 one bit lasts 16 clock cycles when clock-option bit 7 (rate doubling) is 1, and 32 cycles when it is 0.
- R6: In modes 01 and 11 with clock-option bit 0 set to 1, one bit lasts 16*(D+1) cycles, where D = {reg4, reg3}. A write to either divisor register restarts the divisor count from the new value.
- R7: In modes 01 and 11 with clock-option bit 0 set to 0, each `tmr_ovf` pulse is one oversampling tick when rate doubling is 1. When rate doubling is 0, only every second pulse is a tick.
- R8: Control bit 1 (transmit done) and bit 0 (receive done) are set at the end of a frame. A write of 0 to a flag clears it, and a write of 1 leaves it unchanged.
- R9: A stop bit that samples as 0 sets status bit 0. The flag stays set until a 0 is written to that bit.
- R10: When clock-option bit 6 (remap) is 1, control bit 7 reads as the framing-error flag. A write of 0 there clears the flag and a write to it leaves the mode unchanged. When remap is 0, bit 7 reads and writes mode bit 1.
- R11: A low pulse on `rxd` shorter than about half a bit is rejected as a false start and delivers no character.
- R12: In mode 00 a data write sends nothing and `txd` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tmr_ovf | input | 1 | External timer overflow pulse, one cycle wide |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The assertions assume that `tmr_ovf` is a clean single-cycle pulse in the clock domain. They also assume that the mode and clock options change only while both directions are idle, because a mid-frame change would give a frame no requirement describes. The stimulus writes configuration only between frames and drives `tmr_ovf` from a free-running period counter. It sends receive frames whose bit times match the configured rate exactly. Random bytes, ninth bits, modes, divisors and timer periods are drawn inside those limits, and the glitch and framing-error cases are directed.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
    typedef enum logic [1:0] {
        MD_OFF = 2'b00,
        MD_V8  = 2'b01,
        MD_F9  = 2'b10,
        MD_V9  = 2'b11
    } mode_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_RUN  = 1'b1
    } rx_st_e;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_DATA  = 3'd1;
    localparam logic [2:0] A_STAT  = 3'd2;
    localparam logic [2:0] A_DIVLO = 3'd3;
    localparam logic [2:0] A_DIVHI = 3'd4;
    localparam logic [2:0] A_CLK   = 3'd5;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/uart9_tick.sv
module uart9_tick
    import uart9_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic             dbl,
    input  logic             gen_sel,
    input  logic [DIV_W-1:0] div_val,
    input  logic             reload,
    input  logic             tmr_ovf,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             half;
        logic             alt;
    } tk_t;

    tk_t q, d;
    logic gen_hit, tmr_tick, fix_tick;

    always_comb begin
        d        = q;
        gen_hit  = (q.cnt == '0);
        if (reload || gen_hit) d.cnt = div_val;
        else                   d.cnt = q.cnt - 1'b1;
        if (tmr_ovf) d.half = ~q.half;
        d.alt    = ~q.alt;
        tmr_tick = tmr_ovf && (dbl || q.half);
        fix_tick = dbl || q.alt;
        case (mode)
            MD_F9:        tick = fix_tick;
            MD_V8, MD_V9: tick = gen_sel ? (gen_hit && !reload) : tmr_tick;
            default:      tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R7: with halving, a tick never appears without an overflow pulse
    a_r7_tick_needs_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_V8 || mode == MD_V9) && !gen_sel && !dbl && tick) |-> tmr_ovf);

    // R5: slow fixed rate never ticks on two cycles in a row
    a_r5_fixed_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_F9 && !dbl && tick) |=> (!tick || mode != MD_F9 || dbl));
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode_on,
    input  logic              nine,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   bitn;
        logic [3:0]         sub;
        logic               txd;
        logic               done;
    } tx_t;

    tx_t q, d;
    logic [CNT_W-1:0] last;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        last   = nine ? CNT_W'(FRAME_W - 1) : CNT_W'(FRAME_W - 2);
        if (!mode_on) begin
            d.busy = 1'b0;
            d.txd  = 1'b1;
        end else if (!q.busy) begin
            d.txd = 1'b1;
            if (start) begin
                d.busy = 1'b1;
                d.sh   = {1'b1, nine ? bit9 : 1'b1, data, 1'b0};
                d.bitn = '0;
                d.sub  = '0;
                d.txd  = 1'b0;
            end
        end else if (tick) begin
            d.sub = q.sub + 1'b1;
            if (q.sub == 4'd15) begin
                if (q.bitn == last) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.txd  = 1'b1;
                end else begin
                    d.bitn = q.bitn + 1'b1;
                    d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                    d.txd  = q.sh[1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sh: '1, bitn: '0, sub: '0, txd: 1'b1, done: 1'b0};
        else        q <= d;
    end

    assign txd  = q.txd;
    assign busy = q.busy;
    assign done = q.done;

    // R1: a frame opens with the start level on the line
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> (q.txd == 1'b0));

    // R8: a frame that ends normally raises the completion pulse
    a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.busy) && $past(mode_on)) |-> q.done);
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              mode_on,
    input  logic              nine,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              bit9,
    output logic              fe
);
    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(DATA_W + 4);

    typedef struct packed {
        rx_st_e            st;
        logic              prev;
        logic [3:0]        sub;
        logic [CNT_W-1:0]  bitn;
        logic              s7;
        logic              s8;
        logic [SH_W-1:0]   sh;
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              fe;
        logic              done;
    } rx_t;

    rx_t q, d;
    logic v;
    logic [CNT_W-1:0] last;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.prev = rxd;
        v      = maj3(q.s7, q.s8, rxd);
        last   = nine ? CNT_W'(DATA_W + 2) : CNT_W'(DATA_W + 1);
        if (!mode_on) begin
            d.st = RX_IDLE;
        end else if (q.st == RX_IDLE) begin
            if (q.prev && !rxd) begin
                d.st   = RX_RUN;
                d.sub  = '0;
                d.bitn = '0;
            end
        end else if (tick) begin
            d.sub = q.sub + 1'b1;
            if (q.sub == 4'd7) d.s7 = rxd;
            if (q.sub == 4'd8) d.s8 = rxd;
            if (q.sub == 4'd9) begin
                if (q.bitn == '0) begin
                    if (v) d.st = RX_IDLE;
                end else if (q.bitn == last) begin
                    d.st   = RX_IDLE;
                    d.done = 1'b1;
                    d.fe   = !v;
                    d.data = nine ? q.sh[DATA_W-1:0] : q.sh[SH_W-1:1];
                    d.bit9 = nine ? q.sh[SH_W-1] : v;
                end else begin
                    d.sh = {v, q.sh[SH_W-1:1]};
                end
            end
            if (q.sub == 4'd15) d.bitn = q.bitn + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: RX_IDLE, prev: 1'b1, sub: '0, bitn: '0, s7: 1'b1, s8: 1'b1,
                           sh: '0, data: '0, bit9: 1'b0, fe: 1'b0, done: 1'b0};
        else        q <= d;
    end

    assign done = q.done;
    assign data = q.data;
    assign bit9 = q.bit9;
    assign fe   = q.fe;

    // R3: delivering a character always returns the receiver to idle
    a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.st == RX_IDLE));

    // R11: a rejected start never produces a character in the same cycle
    a_r11_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st == RX_RUN && q.bitn == '0) && q.st == RX_IDLE) |-> !q.done);
endmodule

// File: rtl/uart9_core.sv
module uart9_core
    import uart9_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              tmr_ovf,
    input  logic              rxd,
    output logic              txd
);
    localparam int DIV_W  = 2 * BYTE_W;
    localparam int SYNC_N = 2;

    typedef struct packed {
        mode_e             mode;
        logic              tx9;
        logic              rx9;
        logic              txdone;
        logic              rxdone;
        logic              fe;
        logic [BYTE_W-1:0] rxbuf;
        logic [BYTE_W-1:0] txbyte;
        logic              txgo;
        logic [BYTE_W-1:0] divlo;
        logic [BYTE_W-1:0] divhi;
        logic              reload;
        logic              dbl;
        logic              remap;
        logic              gsel;
        logic [SYNC_N-1:0] sync;
    } reg_t;

    reg_t q, d;
    logic tick, mode_on, nine, tx_busy, tx_done, rx_done, rx_bit9, rx_fe;
    logic [BYTE_W-1:0] rx_byte;

    assign mode_on = (q.mode != MD_OFF);
    assign nine    = (q.mode == MD_F9) || (q.mode == MD_V9);

    always_comb begin
        d        = q;
        d.txgo   = 1'b0;
        d.reload = 1'b0;
        d.sync   = {q.sync[SYNC_N-2:0], rxd};
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    if (q.remap) begin
                        if (!wr_data[7]) d.fe = 1'b0;
                    end else begin
                        d.mode = mode_e'({wr_data[7], q.mode[0]});
                    end
                    d.mode = mode_e'({d.mode[1], wr_data[6]});
                    d.tx9  = wr_data[3];
                    if (!wr_data[1]) d.txdone = 1'b0;
                    if (!wr_data[0]) d.rxdone = 1'b0;
                end
                A_DATA: begin
                    d.txbyte = wr_data;
                    d.txgo   = 1'b1;
                end
                A_STAT:  if (!wr_data[0]) d.fe = 1'b0;
                A_DIVLO: begin d.divlo = wr_data; d.reload = 1'b1; end
                A_DIVHI: begin d.divhi = wr_data; d.reload = 1'b1; end
                A_CLK: begin
                    d.dbl   = wr_data[7];
                    d.remap = wr_data[6];
                    d.gsel  = wr_data[0];
                end
                default: ;
            endcase
        end
        if (tx_done) d.txdone = 1'b1;
        if (rx_done) begin
            d.rxdone = 1'b1;
            d.rxbuf  = rx_byte;
            d.rx9    = rx_bit9;
            if (rx_fe) d.fe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTRL:  rd_data = {q.remap ? q.fe : q.mode[1], q.mode[0], 2'b00,
                                q.tx9, q.rx9, q.txdone, q.rxdone};
            A_DATA:  rd_data = q.rxbuf;
            A_STAT:  rd_data = {{(BYTE_W-2){1'b0}}, tx_busy, q.fe};
            A_DIVLO: rd_data = q.divlo;
            A_DIVHI: rd_data = q.divhi;
            A_CLK:   rd_data = {q.dbl, q.remap, {(BYTE_W-3){1'b0}}, q.gsel};
            default: rd_data = '0;
        endcase
    end

    uart9_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .mode(q.mode), .dbl(q.dbl), .gen_sel(q.gsel),
        .div_val({q.divhi, q.divlo}), .reload(q.reload), .tmr_ovf(tmr_ovf), .tick(tick)
    );

    uart9_tx #(.DATA_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_on(mode_on), .nine(nine),
        .start(q.txgo), .data(q.txbyte), .bit9(q.tx9),
        .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    uart9_rx #(.DATA_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_on(mode_on), .nine(nine),
        .rxd(q.sync[SYNC_N-1]), .done(rx_done), .data(rx_byte), .bit9(rx_bit9), .fe(rx_fe)
    );

    // R12: with the port switched off the line rests high
    a_r12_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.mode == MD_OFF) |-> txd);

    // R9: a received character with a bad stop leaves the error flag set
    a_r9_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_fe) |=> q.fe);
endmodule

// File: tb/sim_uart9_core.sv
module sim_uart9_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tmr_ovf = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;

    int n_chk = 0;
    int n_bad = 0;
    int tper = 3;
    int tcnt = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    uart9_core u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tmr_ovf(tmr_ovf), .rxd(rxd), .txd(txd));

    always @(negedge clk) begin
        if (tcnt >= tper - 1) begin tcnt <= 0; tmr_ovf <= 1'b1; end
        else begin tcnt <= tcnt + 1; tmr_ovf <= 1'b0; end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp=finish", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic int bitlen(input int md, input int dbl, input int gs, input int dv, input int tp);
        if (md == 2) return dbl ? 16 : 32;
        if (gs) return 16 * (dv + 1);
        return dbl ? 16 * tp : 32 * tp;
    endfunction

    function automatic logic [10:0] frame(input int md, input logic [7:0] b, input logic n9);
        if (md == 1) return {1'b1, 1'b1, b, 1'b0};
        return {1'b1, n9, b, 1'b0};
    endfunction

    task automatic setup(input int md, input int dbl, input int gs, input int dv, input int tp, input logic t9);
        tper = tp;
        wr(3'd5, {dbl[0], 6'b0, gs[0]});
        wr(3'd4, dv[15:8]);
        wr(3'd3, dv[7:0]);
        wr(3'd0, {md[1:0], 2'b00, t9, 1'b0, 2'b00});
    endtask

    task automatic tx_grab(input int bl, input int nb, output logic [10:0] got);
        int w = 0;
        got = '1;
        @(negedge clk);
        while (txd !== 1'b0 && w < 20000) begin @(negedge clk); w++; end
        repeat (bl / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < nb; i++) begin
            repeat (bl) @(negedge clk);
            got[i] = txd;
        end
        repeat (bl) @(negedge clk);
    endtask

    task automatic rx_send(input int bl, input logic [7:0] b, input logic n9, input logic has9, input logic stopv);
        logic [10:0] f;
        int nb;
        f  = has9 ? {stopv, n9, b, 1'b0} : {1'b0, stopv, b, 1'b0};
        nb = has9 ? 11 : 10;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk); rxd = f[i];
            repeat (bl - 1) @(negedge clk);
        end
        @(negedge clk); rxd = 1'b1;
        repeat (bl) @(negedge clk);
    endtask

    initial begin
        logic [7:0]  v;
        logic [10:0] got;
        void'($urandom(32'h5eed_0009));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(3'd0, v); check("R8 reset control", v, 8'h00);
        rd(3'd2, v); check("R9 reset status", v, 8'h00);
        check("R1 idle line", txd, 1);

        // R12: mode off sends nothing
        wr(3'd1, 8'h5a);
        repeat (400) @(negedge clk);
        check("R12 txd stays high", txd, 1);
        rd(3'd0, v); check("R12 no done flag", v[1], 0);

        // R5 + R2 fixed 9-bit, both rates
        setup(2, 1, 0, 0, 3, 1'b1);
        wr(3'd1, 8'hc3);
        tx_grab(16, 11, got); check("R5 fast fixed frame", got, frame(2, 8'hc3, 1'b1));
        setup(2, 0, 0, 0, 3, 1'b0);
        wr(3'd1, 8'h3c);
        tx_grab(32, 11, got); check("R5 slow fixed frame", got, frame(2, 8'h3c, 1'b0));

        // R6 divisor restart: huge divisor replaced by small one
        setup(1, 1, 1, 60000, 3, 1'b0);
        wr(3'd4, 8'h00);
        wr(3'd3, 8'h02);
        wr(3'd1, 8'ha5);
        tx_grab(48, 10, got); check("R6 restart after divisor write", got, frame(1, 8'ha5, 1'b0));
        rd(3'd0, v); check("R8 tx done set", v[1], 1);
        wr(3'd0, 8'h43);
        rd(3'd0, v); check("R8 write 1 keeps flag", v[1], 1);
        wr(3'd0, 8'h40);
        rd(3'd0, v); check("R8 write 0 clears flag", v[1], 0);

        // R9 / R10 framing error in 8-bit mode, divisor 0 -> 16 clocks per bit
        setup(1, 1, 1, 0, 3, 1'b0);
        rx_send(16, 8'h96, 1'b0, 1'b0, 1'b0);
        rd(3'd2, v); check("R9 framing error", v[0], 1);
        rd(3'd0, v); check("R3 stop bit stored", v[2], 0);
        check("R10 bit7 is mode when remap off", v[7], 0);
        wr(3'd5, 8'h41);
        rd(3'd0, v); check("R10 bit7 shows error", v[7], 1);
        wr(3'd0, 8'h40);
        rd(3'd2, v); check("R10 write 0 clears error", v[0], 0);
        wr(3'd0, 8'hc0);
        wr(3'd5, 8'h01);
        rd(3'd0, v); check("R10 mode untouched", v[7:6], 2'b01);

        // R11 false start glitch
        setup(2, 1, 0, 0, 3, 1'b0);
        @(negedge clk); rxd = 1'b0;
        repeat (3) @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        rd(3'd0, v); check("R11 glitch rejected", v[0], 0);

        // random frames over all modes and sources
        for (int it = 0; it < 16; it++) begin
            int md, dbl, gs, dv, tp, bl;
            logic [7:0] b;
            logic n9;
            md  = 1 + int'($urandom_range(2));
            dbl = int'($urandom_range(1));
            gs  = int'($urandom_range(1));
            dv  = int'($urandom_range(3));
            tp  = 2 + int'($urandom_range(2));
            b   = 8'($urandom);
            n9  = 1'($urandom);
            bl  = bitlen(md, dbl, gs, dv, tp);
            setup(md, dbl, gs, dv, tp, n9);
            wr(3'd1, b);
            tx_grab(bl, (md == 1) ? 10 : 11, got);
            if (md == 1) check("R1 8-bit frame", got[9:0], frame(md, b, n9) & 11'h3ff);
            else if (md == 2) check("R2 R5 fixed 9-bit frame", got, frame(md, b, n9));
            else check("R2 R6 R7 variable 9-bit frame", got, frame(md, b, n9));
            b  = 8'($urandom);
            n9 = 1'($urandom);
            rx_send(bl, b, n9, md != 1, 1'b1);
            rd(3'd1, v); check("R3 R4 received byte", v, b);
            rd(3'd0, v);
            check("R8 rx done", v[0], 1);
            if (md == 1) check("R3 stop in ninth position", v[2], 1);
            else check("R4 ninth bit", v[2], n9);
            rd(3'd2, v); check("R9 no error", v[0], 0);
            wr(3'd0, {md[1:0], 6'b0});
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule